// File: doc/BRIEF.md
# Triangular-Sweep PWM Generator

This block produces a single-bit pulse-width-modulated output whose duty cycle climbs from 0% to 100% in equal 10% steps, one step per PWM period, and then falls back to 0% in the same steps. The sweep repeats without end. An external low-pass filter turns the output into a repeating triangular ramp, which can serve as the reference for a slope-type converter. At the intended 200 MHz clock, one PWM period is 20 clocks (100 ns). A full ramp is 20 periods, or 400 clocks, which gives a 500 kHz ramp rate.

The duty cycle is not produced by a counter and comparator. A shadow shift register holds the current duty pattern as a thermometer code. On each step strobe, this pattern grows by two ones or shrinks by two ones, depending on the direction level. A second register rotates by one bit every clock and drives the output. It reloads from the shadow pattern only at a period boundary, so every period on the output is complete. A small synchroniser produces the one-clock step strobe and the up/down direction level. Both are brought out so the sweep can be observed.

An enable input pauses the whole sweep in place. While enable is low, the output holds its current level.

Top module: `tsweep_pwm`

## Requirements
- R1: While reset is low at a clock edge, the block returns to its start state: `pwm_o` low, `step_o` low, `dir_o` high (up), 0% duty, and period position zero.
- R2: With enable held high, `step_o` is high for exactly one clock in every 20-clock period, and that clock is the last one of the period.
- R3: In a period whose duty level is k steps (k = 0..10), `pwm_o` is high for the first 2k clocks of the period and low for the remaining 20 − 2k clocks.
- R4: The duty level is 0 in the first period after reset. It rises by one step per period up to 10, then falls by one step per period down to 0, so one ramp lasts 20 periods (400 clocks) and then repeats.
- R5: `dir_o` is high (1 = up) while the level rises. It goes low on the second clock of the period that reaches level 10. It goes high again on the second clock of the period that returns to level 0.
- R6: At level 0, `pwm_o` stays low for all 20 clocks of the period. At level 10, it stays high for all 20 clocks. There are no single-clock glitches in either case.
- R7: While `en` is low, `pwm_o` and `dir_o` hold their values and `step_o` is low. The position in the sweep does not advance. When `en` returns high, the period continues from the clock at which it stopped.
- R8: The duty pattern changes only at a step strobe. A period that has started on the output always plays out the pattern it began with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 200 MHz intended |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low freezes the sweep |
| pwm_o | output | 1 | PWM output bit |
| step_o | output | 1 | One-clock duty step strobe (observation) |
| dir_o | output | 1 | Sweep direction, 1 = rising duty (observation) |

## Verification
The embedded properties assume several things about the inputs. They assume `en` may change on any clock. They assume reset is released only on a clock edge. They assume the period is longer than one clock, so two strobes are never adjacent. The direction checks also assume that the shadow pattern is only ever a thermometer code, which the stimulus cannot break, because the pattern is reachable only through the step path. The stimulus drives `en` and `rst_n` only at falling clock edges. It pauses the sweep both in the middle of a period and on the strobe clock itself. It applies reset in the middle of a ramp. All of these stay within the assumptions above.

// File: rtl/tsweep_pkg.sv
`timescale 1ns/1ps
// Package: shared parameters and types for the triangular-sweep PWM generator.
// Assumes PERIOD_LEN is a whole multiple of STEP_BITS.
package tsweep_pkg;
    // Clocks per PWM period (one bit per clock in the pattern).
    localparam int PERIOD_LEN = 20;
    // Pattern bits added or removed per duty step (2 of 20 = 10%).
    localparam int STEP_BITS  = 2;

    // Sweep direction level as seen on dir_o.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } sweep_dir_e;
endpackage

// File: rtl/tsweep_phase.sv
`timescale 1ns/1ps
// Module: tsweep_phase
// Tracks the clock position inside one PWM period and flags its last clock.
// Assumes: en_i freezes the position; synchronous active-low reset.
module tsweep_phase #(
    parameter int LEN = tsweep_pkg::PERIOD_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic last_o
);
    localparam int PH_W = $clog2(LEN);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(LEN - 1);

    logic [PH_W-1:0] ph_q;

    // Advance the period position while enabled, wrapping after the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (en_i) begin
            ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
        end
    end

    assign last_o = (ph_q == LAST_PH);

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && last_o) |=> (ph_q == '0));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= LAST_PH);
endmodule

// File: rtl/tsweep_sync.sv
`timescale 1ns/1ps
// Module: tsweep_sync
// Issues the one-clock step strobe at the last clock of each period and keeps
// the up/down direction level, turning it when the pattern is full or empty.
// Assumes: full_i/empty_i come from the shadow pattern register.
module tsweep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic last_i,
    input  logic full_i,
    input  logic empty_i,
    output logic step_o,
    output logic dir_o
);
    import tsweep_pkg::*;

    sweep_dir_e dir_q;

    // Strobe only while running, so a paused sweep never steps.
    assign step_o = en_i && last_i;

    // Turn the sweep at the top and bottom of the ramp; hold while paused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
        end else if (en_i) begin
            if (full_i) begin
                dir_q <= DIR_DOWN;
            end else if (empty_i) begin
                dir_q <= DIR_UP;
            end
        end
    end

    assign dir_o = (dir_q == DIR_UP);

    // R2
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R5
    dir_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && full_i) |=> !dir_o);

    // R5
    dir_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && empty_i) |=> dir_o);

    // R7
    dir_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(dir_o));
endmodule

// File: rtl/tsweep_wave.sv
`timescale 1ns/1ps
// Module: tsweep_wave
// Holds the duty pattern as a thermometer code in a shadow register, grows or
// shrinks it by STEP_BITS on each strobe, and rotates a copy one bit per clock
// to drive the output. The copy reloads only on the strobe (period boundary).
// Assumes: step_i is high only on the last clock of a period.
module tsweep_wave #(
    parameter int LEN  = tsweep_pkg::PERIOD_LEN,
    parameter int STEP = tsweep_pkg::STEP_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic step_i,
    input  logic dir_i,
    output logic pwm_o,
    output logic full_o,
    output logic empty_o
);
    logic [LEN-1:0] shadow_q;
    logic [LEN-1:0] rot_q;
    logic [LEN-1:0] grow_w;
    logic [LEN-1:0] shrink_w;
    logic [LEN-1:0] next_w;

    // Build the grown and shrunk thermometer patterns bit by bit.
    for (genvar i = 0; i < LEN; i++) begin : g_bits
        if (i < STEP) begin : g_fill
            assign grow_w[i] = 1'b1;
        end else begin : g_move_up
            assign grow_w[i] = shadow_q[i-STEP];
        end
        if (i + STEP < LEN) begin : g_move_dn
            assign shrink_w[i] = shadow_q[i+STEP];
        end else begin : g_clear
            assign shrink_w[i] = 1'b0;
        end
    end

    assign next_w = dir_i ? grow_w : shrink_w;

    // Update the stored duty pattern once per period on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (en_i && step_i) begin
            shadow_q <= next_w;
        end
    end

    // Rotate the output copy each clock; reload it at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_q <= '0;
        end else if (en_i) begin
            rot_q <= step_i ? next_w : {rot_q[0], rot_q[LEN-1:1]};
        end
    end

    assign pwm_o   = rot_q[0];
    assign full_o  = &shadow_q;
    assign empty_o = ~|shadow_q;

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && step_i) |=> $stable(shadow_q));

    // R7
    rot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(rot_q));

    // R3
    thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q & (shadow_q + {{(LEN-1){1'b0}}, 1'b1})) == '0);

    // R6
    top_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i && full_o) |=> ($countones(rot_q) >= LEN - STEP));
endmodule

// File: rtl/tsweep_pwm.sv
`timescale 1ns/1ps
// Module: tsweep_pwm (top)
// Triangular-sweep PWM: the duty cycle rises 0%..100% and falls back in fixed
// steps, one step per PWM period, built from shift registers only.
// Assumes: en and rst_n are synchronous to clk.
module tsweep_pwm #(
    parameter int PERIOD_LEN = tsweep_pkg::PERIOD_LEN,
    parameter int STEP_BITS  = tsweep_pkg::STEP_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pwm_o,
    output logic step_o,
    output logic dir_o
);
    logic last_w;
    logic full_w;
    logic empty_w;

    // Period position tracker.
    tsweep_phase #(.LEN(PERIOD_LEN)) phase_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .last_o (last_w)
    );

    // Step strobe and direction level.
    tsweep_sync sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .last_i  (last_w),
        .full_i  (full_w),
        .empty_i (empty_w),
        .step_o  (step_o),
        .dir_o   (dir_o)
    );

    // Duty pattern storage and output rotation.
    tsweep_wave #(.LEN(PERIOD_LEN), .STEP(STEP_BITS)) wave_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .step_i  (step_o),
        .dir_i   (dir_o),
        .pwm_o   (pwm_o),
        .full_o  (full_w),
        .empty_o (empty_w)
    );
endmodule

// File: tb/tsweep_pwm_tb_top.sv
`timescale 1ns/1ps
// Bench: walks a table of per-period expected duty levels and directions, then
// runs directed tests for pausing and mid-ramp reset.
module tsweep_pwm_tb_top;
    localparam int LEN    = 20;
    localparam int NROWS  = 22;
    // Expected duty level (steps of 2 bits) per period after reset.
    localparam int EXP_LVL [NROWS] = '{0,1,2,3,4,5,6,7,8,9,10,9,8,7,6,5,4,3,2,1,0,1};
    // Expected direction at mid-period (1 = up).
    localparam bit EXP_DIR [NROWS] = '{1,1,1,1,1,1,1,1,1,1,0,0,0,0,0,0,0,0,0,0,1,1};

    logic clk = 1'b0;
    logic rst_n;
    logic en;
    logic pwm_o, step_o, dir_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tsweep_pwm dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .pwm_o  (pwm_o),
        .step_o (step_o),
        .dir_o  (dir_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Play one period, sampling each clock; optional pause at sample freeze_at.
    task automatic run_period(input int lvl, input bit dir, input int freeze_at);
        int bad_pat  = 0;
        int bad_step = 0;
        int highs    = 0;
        int steps    = 0;
        for (int j = 0; j < LEN; j++) begin
            #1;
            if (pwm_o) highs++;
            if (step_o) steps++;
            if (pwm_o != (j < 2*lvl)) bad_pat++;
            if (step_o != (j == LEN-1)) bad_step++;
            if (j == LEN/2) chk(dir_o == dir, "R5 dir", dir_o, dir);
            if (j == freeze_at) begin
                logic held = pwm_o;
                logic hdir = dir_o;
                int bad_fz = 0;
                en = 1'b0;
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk); #1;
                    if (pwm_o != held || dir_o != hdir || step_o) bad_fz++;
                end
                chk(bad_fz == 0, "R7 freeze", bad_fz, 0);
                en = 1'b1;
            end
            @(negedge clk);
        end
        chk(bad_pat == 0, (lvl == 0 || lvl == 10) ? "R6 flat period" : "R3 pattern", highs, 2*lvl);
        chk(bad_step == 0 && steps == 1, "R2 strobe", steps, 1);
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(pwm_o == 1'b0, "R1 pwm", pwm_o, 0);
        chk(step_o == 1'b0, "R1 step", step_o, 0);
        chk(dir_o == 1'b1, "R1 dir", dir_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        en    = 1'b1;
        // R4 table walk: full ramp plus the start of the next one
        for (int n = 0; n < NROWS; n++) begin
            run_period(EXP_LVL[n], EXP_DIR[n], -1);
        end
        // R7 pause while the output is high mid-period
        run_period(2, 1'b1, 1);
        // R7 pause on the strobe clock itself
        run_period(3, 1'b1, LEN-1);
        run_period(4, 1'b1, -1);
        // R8 reset mid-ramp, then restart from level 0
        run_period(5, 1'b1, -1);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(pwm_o == 1'b0 && step_o == 1'b0, "R1 mid reset outputs", {pwm_o, step_o}, 0);
        chk(dir_o == 1'b1, "R1 mid reset dir", dir_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        run_period(0, 1'b1, -1);
        run_period(1, 1'b1, -1);
        run_period(2, 1'b1, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule